// File: doc/BRIEF.md
# Idle-Gap Transmit Timer

This block decides how long the single-wire consumer-control bus must have been quiet before this node may begin a new frame. It then times that quiet period and issues a one-clock transmit permission. All time is kept in half-bit ticks, supplied by an external tick pulse at twice the nominal bit rate. The block sets no bus timing of its own and takes no part in line sampling, bit encoding or shifting.

A 3-bit selection value picks the wait. Values 1 to 7 give a fixed wait of (value − 0.5) bit periods. Value 0 hands the choice to hardware, which bases it on how this node's own last frame ended. A failed attempt gives a short wait, a fresh start gives a medium wait, and a completed frame gives a long wait, so that other nodes get a fair turn. The selection can be loaded only while the controller is disabled. Outcome pulses come from the transmitter of the previous frame. A separate pulse reports that some other node has completed a frame.

Top module: `idle_gap_timer`

## Requirements
- R1: After reset the grant output is low, the selection value is 0 (automatic), and the history is "new initiator".
- R2: Selection value c in 1..7 sets the wait to 2c−1 half-bit ticks, whatever the history is.
- R3: With selection 0 and history "new initiator", the wait is 8 half-bit ticks.
- R4: With selection 0, any of the pulses arbitration-lost, transmit-error, underrun or missing-acknowledge moves the history to "failed", and the wait becomes 5 ticks. A failure pulse wins over an end-of-message pulse arriving in the same cycle.
- R5: With selection 0, an end-of-message-sent pulse moves the history to "succeeded", and the wait becomes 12 ticks.
- R6: A peer-frame-complete pulse with no own-outcome pulse in the same cycle returns the history to "new initiator".
- R7: A configuration write is taken only while the controller enable is low. While the enable is high, a write leaves the selection unchanged.
- R8: A cycle with the line not idle clears the count to zero. So does a cycle with the controller disabled. Counting then starts again from the beginning.
- R9: The grant is a one-clock pulse. It is raised only when a request was present and the count had reached the wait, and the count restarts after it. The count holds at the wait while no request is pending. A request that arrives later is granted on the next clock.
- R10: The grant appears one clock after the tick that completes the wait, provided the request and line-idle inputs are already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_en_i | input | 1 | Controller enable; the configuration is frozen while high |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Wait selection to write (0 = automatic, 1..7 fixed) |
| tx_req_i | input | 1 | A transmission is pending |
| line_idle_i | input | 1 | Bus line currently idle |
| half_tick_i | input | 1 | One-cycle pulse per half nominal bit period |
| ev_arb_lost_i | input | 1 | Own frame lost arbitration |
| ev_tx_err_i | input | 1 | Own frame had a transmit error |
| ev_underrun_i | input | 1 | Own frame ran out of data |
| ev_nack_i | input | 1 | Own frame was not acknowledged |
| ev_eom_ok_i | input | 1 | Own frame completed successfully |
| ev_peer_frame_i | input | 1 | Another node completed a frame |
| tx_grant_o | output | 1 | One-clock transmit permission |

## Verification
The bench uses the default parameters: a 3-bit selection and automatic waits of 5, 8 and 12 ticks. With these, every fixed code and all three history states can be reached, and the longest wait of 13 ticks takes only a few dozen cycles. The wait is measured by counting ticks until the grant appears, one idle cycle after each tick. The count must land exactly on the expected value, so a wait that is off by one tick is caught. Restart, frozen-configuration and late-request cases are run through the same measurement.

// File: rtl/idle_gap_pkg.sv
package idle_gap_pkg;

  typedef enum logic [1:0] {
    HIST_NEW  = 2'd0,
    HIST_FAIL = 2'd1,
    HIST_OK   = 2'd2
  } hist_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/gap_cfg_reg.sv
module gap_cfg_reg #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_en_i,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] sel_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (we_i && !ctrl_en_i) begin
      sel_q <= sel_i;
    end
  end

endmodule

// File: rtl/gap_history.sv
module gap_history
  import idle_gap_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  arb_lost_i,
  input  logic  tx_err_i,
  input  logic  underrun_i,
  input  logic  nack_i,
  input  logic  eom_ok_i,
  input  logic  peer_frame_i,
  output hist_e hist_q
);

  logic any_fail;
  assign any_fail = arb_lost_i | tx_err_i | underrun_i | nack_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= HIST_NEW;
    end else if (any_fail) begin
      hist_q <= HIST_FAIL;
    end else if (eom_ok_i) begin
      hist_q <= HIST_OK;
    end else if (peer_frame_i) begin
      hist_q <= HIST_NEW;
    end
  end

endmodule

// File: rtl/gap_len_sel.sv
module gap_len_sel
  import idle_gap_pkg::*;
#(
  parameter int SEL_W      = 3,
  parameter int CNT_W      = 4,
  parameter int FAIL_TICKS = 5,
  parameter int NEW_TICKS  = 8,
  parameter int OK_TICKS   = 12
) (
  input  logic [SEL_W-1:0] sel_i,
  input  hist_e            hist_i,
  output logic [CNT_W-1:0] need_o
);

  localparam int N_CODES = 1 << SEL_W;

  logic [CNT_W-1:0] fixed_tbl [N_CODES];
  logic [CNT_W-1:0] auto_need;

  for (genvar gi = 0; gi < N_CODES; gi++) begin : g_tbl
    if (gi == 0) begin : g_auto
      assign fixed_tbl[gi] = '0;
    end else begin : g_fix
      assign fixed_tbl[gi] = CNT_W'(2 * gi - 1);
    end
  end

  always_comb begin
    unique case (hist_i)
      HIST_FAIL: auto_need = CNT_W'(FAIL_TICKS);
      HIST_OK:   auto_need = CNT_W'(OK_TICKS);
      default:   auto_need = CNT_W'(NEW_TICKS);
    endcase
  end

  assign need_o = (sel_i == '0) ? auto_need : fixed_tbl[sel_i];

endmodule

// File: rtl/gap_counter.sv
module gap_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_en_i,
  input  logic             line_idle_i,
  input  logic             half_tick_i,
  input  logic             tx_req_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             grant_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             reached;

  assign reached = (cnt_q >= need_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      grant_o <= 1'b0;
    end else begin
      grant_o <= 1'b0;
      if (!ctrl_en_i || !line_idle_i) begin
        cnt_q <= '0;
      end else if (reached && tx_req_i) begin
        grant_o <= 1'b1;
        cnt_q   <= '0;
      end else if (half_tick_i && !reached) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/idle_gap_timer.sv
module idle_gap_timer
  import idle_gap_pkg::*;
#(
  parameter int SEL_W      = 3,
  parameter int FAIL_TICKS = 5,
  parameter int NEW_TICKS  = 8,
  parameter int OK_TICKS   = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_en_i,
  input  logic             cfg_we_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic             tx_req_i,
  input  logic             line_idle_i,
  input  logic             half_tick_i,
  input  logic             ev_arb_lost_i,
  input  logic             ev_tx_err_i,
  input  logic             ev_underrun_i,
  input  logic             ev_nack_i,
  input  logic             ev_eom_ok_i,
  input  logic             ev_peer_frame_i,
  output logic             tx_grant_o
);

  localparam int FIX_MAX = 2 * ((1 << SEL_W) - 1) - 1;
  localparam int TOP_MAX = max3(max3(FAIL_TICKS, NEW_TICKS, OK_TICKS), FIX_MAX, 1);
  localparam int CNT_W   = $clog2(TOP_MAX + 1);

  logic [SEL_W-1:0] sel_q;
  hist_e            hist_q;
  logic [CNT_W-1:0] need;

  gap_cfg_reg #(.SEL_W(SEL_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .ctrl_en_i (ctrl_en_i),
    .we_i      (cfg_we_i),
    .sel_i     (cfg_sel_i),
    .sel_q     (sel_q)
  );

  gap_history u_hist (
    .clk          (clk),
    .rst          (rst),
    .arb_lost_i   (ev_arb_lost_i),
    .tx_err_i     (ev_tx_err_i),
    .underrun_i   (ev_underrun_i),
    .nack_i       (ev_nack_i),
    .eom_ok_i     (ev_eom_ok_i),
    .peer_frame_i (ev_peer_frame_i),
    .hist_q       (hist_q)
  );

  gap_len_sel #(
    .SEL_W      (SEL_W),
    .CNT_W      (CNT_W),
    .FAIL_TICKS (FAIL_TICKS),
    .NEW_TICKS  (NEW_TICKS),
    .OK_TICKS   (OK_TICKS)
  ) u_sel (
    .sel_i  (sel_q),
    .hist_i (hist_q),
    .need_o (need)
  );

  gap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .ctrl_en_i   (ctrl_en_i),
    .line_idle_i (line_idle_i),
    .half_tick_i (half_tick_i),
    .tx_req_i    (tx_req_i),
    .need_i      (need),
    .grant_o     (tx_grant_o)
  );

endmodule

// File: rtl/idle_gap_timer_chk.sv
module idle_gap_timer_chk
  import idle_gap_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ctrl_en_i,
  input logic             tx_req_i,
  input logic             line_idle_i,
  input logic             ev_arb_lost_i,
  input logic             ev_tx_err_i,
  input logic             ev_underrun_i,
  input logic             ev_nack_i,
  input logic             ev_eom_ok_i,
  input logic             ev_peer_frame_i,
  input logic             tx_grant_o,
  input logic [SEL_W-1:0] sel_q,
  input hist_e            hist_q
);

  AST_GRANT_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    tx_grant_o |=> !tx_grant_o); // R9

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    tx_grant_o |-> $past(tx_req_i)); // R9

  AST_BUSY_BLOCKS_GRANT: assert property (@(posedge clk) disable iff (rst)
    (!line_idle_i || !ctrl_en_i) |=> !tx_grant_o); // R8

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_en_i) |-> $stable(sel_q)); // R7

  AST_FAIL_RECORDED: assert property (@(posedge clk) disable iff (rst)
    (ev_arb_lost_i || ev_tx_err_i || ev_underrun_i || ev_nack_i) |=> hist_q == HIST_FAIL); // R4

  AST_OK_RECORDED: assert property (@(posedge clk) disable iff (rst)
    (ev_eom_ok_i && !(ev_arb_lost_i || ev_tx_err_i || ev_underrun_i || ev_nack_i))
      |=> hist_q == HIST_OK); // R5

  AST_PEER_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ev_peer_frame_i && !(ev_arb_lost_i || ev_tx_err_i || ev_underrun_i || ev_nack_i || ev_eom_ok_i))
      |=> hist_q == HIST_NEW); // R6

endmodule

bind idle_gap_timer idle_gap_timer_chk #(.SEL_W(SEL_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .ctrl_en_i       (ctrl_en_i),
  .tx_req_i        (tx_req_i),
  .line_idle_i     (line_idle_i),
  .ev_arb_lost_i   (ev_arb_lost_i),
  .ev_tx_err_i     (ev_tx_err_i),
  .ev_underrun_i   (ev_underrun_i),
  .ev_nack_i       (ev_nack_i),
  .ev_eom_ok_i     (ev_eom_ok_i),
  .ev_peer_frame_i (ev_peer_frame_i),
  .tx_grant_o      (tx_grant_o),
  .sel_q           (sel_q),
  .hist_q          (hist_q)
);

// File: tb/idle_gap_timer_tb_top.sv
`timescale 1ns/1ps
module idle_gap_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctrl_en = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_sel = 3'd0;
  logic       tx_req = 1'b0;
  logic       line_idle = 1'b0;
  logic       half_tick = 1'b0;
  logic       ev_arb = 1'b0, ev_err = 1'b0, ev_udr = 1'b0, ev_nack = 1'b0;
  logic       ev_eom = 1'b0, ev_peer = 1'b0;
  logic       grant;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  idle_gap_timer dut_i (
    .clk             (clk),
    .rst             (rst),
    .ctrl_en_i       (ctrl_en),
    .cfg_we_i        (cfg_we),
    .cfg_sel_i       (cfg_sel),
    .tx_req_i        (tx_req),
    .line_idle_i     (line_idle),
    .half_tick_i     (half_tick),
    .ev_arb_lost_i   (ev_arb),
    .ev_tx_err_i     (ev_err),
    .ev_underrun_i   (ev_udr),
    .ev_nack_i       (ev_nack),
    .ev_eom_ok_i     (ev_eom),
    .ev_peer_frame_i (ev_peer),
    .tx_grant_o      (grant)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart_line();
    line_idle = 1'b0;
    @(negedge clk);
    line_idle = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [2:0] v);
    cfg_we = 1'b1; cfg_sel = v;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  // Ticks until grant seen one idle cycle after a tick; 99 if none within 20.
  task automatic measure(output int n);
    n = 99;
    for (int k = 1; k <= 20; k++) begin
      half_tick = 1'b1;
      @(negedge clk);
      half_tick = 1'b0;
      @(negedge clk);
      if (grant) begin
        n = k;
        break;
      end
    end
  endtask

  task automatic pulse_fail(input int kind);
    case (kind)
      0: ev_arb = 1'b1;
      1: ev_err = 1'b1;
      2: ev_udr = 1'b1;
      default: ev_nack = 1'b1;
    endcase
    @(negedge clk);
    ev_arb = 1'b0; ev_err = 1'b0; ev_udr = 1'b0; ev_nack = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_eom();
    ev_eom = 1'b1; @(negedge clk); ev_eom = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_peer();
    ev_peer = 1'b1; @(negedge clk); ev_peer = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    int n;
    check("R1 grant low after reset", int'(grant), 0);
    ctrl_en = 1'b1; tx_req = 1'b1;
    restart_line();
    measure(n);
    check("R1/R3 reset selects automatic new-initiator wait", n, 8);
    check("R9 grant lasts one clock", int'(grant), 1);
    @(negedge clk);
    check("R9 grant dropped next clock", int'(grant), 0);
  endtask

  task automatic t_fixed();
    int n;
    for (int c = 1; c <= 7; c++) begin
      ctrl_en = 1'b0;
      write_cfg(3'(c));
      ctrl_en = 1'b1;
      restart_line();
      measure(n);
      check($sformatf("R2 fixed code %0d", c), n, 2 * c - 1);
      @(negedge clk);
    end
  endtask

  task automatic t_auto();
    int n;
    ctrl_en = 1'b0; write_cfg(3'd0); ctrl_en = 1'b1;
    for (int kind = 0; kind < 4; kind++) begin
      pulse_peer();
      pulse_fail(kind);
      restart_line(); measure(n);
      check($sformatf("R4 failure kind %0d gives short wait", kind), n, 5);
      @(negedge clk);
    end
    pulse_eom();
    restart_line(); measure(n);
    check("R5 success gives long wait", n, 12);
    @(negedge clk);
    pulse_peer();
    restart_line(); measure(n);
    check("R6 peer frame returns to new-initiator wait", n, 8);
    @(negedge clk);
    ev_eom = 1'b1; ev_nack = 1'b1;
    @(negedge clk);
    ev_eom = 1'b0; ev_nack = 1'b0;
    @(negedge clk);
    restart_line(); measure(n);
    check("R4 failure wins over simultaneous success", n, 5);
    @(negedge clk);
  endtask

  task automatic t_fixed_ignores_history();
    int n;
    pulse_eom();
    ctrl_en = 1'b0; write_cfg(3'd3); ctrl_en = 1'b1;
    restart_line(); measure(n);
    check("R2 fixed code ignores success history", n, 5);
    @(negedge clk);
  endtask

  task automatic t_frozen();
    int n;
    ctrl_en = 1'b1;
    write_cfg(3'd7);
    restart_line(); measure(n);
    check("R7 write while enabled ignored", n, 5);
    @(negedge clk);
  endtask

  task automatic t_restart();
    int n;
    restart_line();
    for (int k = 0; k < 3; k++) begin
      half_tick = 1'b1; @(negedge clk); half_tick = 1'b0; @(negedge clk);
    end
    restart_line();
    measure(n);
    check("R8 line activity restarts count", n, 5);
    @(negedge clk);
    ctrl_en = 1'b0;
    line_idle = 1'b1;
    measure(n);
    check("R8 disabled controller never grants", n, 99);
    ctrl_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_late_req();
    int n;
    tx_req = 1'b0;
    restart_line();
    measure(n);
    check("R9 no grant without request", n, 99);
    tx_req = 1'b1;
    @(negedge clk);
    check("R9/R10 late request granted next clock", int'(grant), 1);
    @(negedge clk);
    check("R9 count restarts after grant", int'(grant), 0);
    restart_line(); measure(n);
    check("R10 grant one clock after final tick", n, 5);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_auto();
    t_fixed_ignores_history();
    t_frozen();
    t_restart();
    t_late_req();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule